// File: doc/BRIEF.md
# Bus Mode Address Decoder

This block sits between a CPU core and the memory system of a small controller. For every read or write cycle it decides whether the 22-bit address belongs to on-chip memory or to the external expansion bus. It then drives one internal region select, or the active-low external chip enable, read and write strobes. It also drives a data bus output enable, a data bus pull-up control and a flag that hands the bus pins over to general-purpose port use.

Two settings shape the decode:

- **Start mode.** A configuration pin chooses between running from internal ROM (MCU) and running from external memory (MPU). The pin is captured while reset is held and stays frozen until the next reset.
- **Bus mode.** Software chooses between single chip operation and expansion operation through a one-cycle configuration write. The same write also loads the pull-up control bit.

Every decode result appears on registered outputs one clock after the access is presented.

Top module: `bus_mode_decoder`

## Requirements
- R1: `mode_pin` is sampled on every clock edge while `rst` is high and the value is held once `rst` falls (1 = MCU, 0 = MPU). Later changes on the pin have no effect until reset is asserted again.
- R2: During and after reset all select lines are 0 and every external strobe is high. `unmapped` and `data_pullup` are 0. The bus mode starts as single chip under MCU and as expansion under MPU, so `gpio_free` equals the captured pin value.
- R3: A configuration write with `cfg_single`=1 while in MPU mode is refused, and the bus stays in expansion mode. In MCU mode the same write is accepted.
- R4: `int_sel` is one-hot or zero, with bit 0 = ROM 000000H–00BFFFH (MCU only), bit 1 = RAM 00C000H–00D7FFH, bit 2 = display 00D800H–00F7FFH, bit 3 = I/O 00FF00H–00FFFFH and bit 4 = font ROM 010000H–0EFFFFH. It is valid one cycle after the access.
- R5: In MCU expansion mode an access goes external only for addresses 100000H–3FFFFFH.
- R6: In MPU expansion mode addresses 000000H–00BFFFH and 0F0000H–2FFFFFH go external. Addresses 00C000H–00FFFFH and the font ROM stay internal.
- R7: On an internal hit `ext_ce_n`, `ext_rd_n` and `ext_wr_n` stay high and `data_oe` stays low.
- R8: On an external access `ext_ce_n` goes low together with `ext_rd_n` for a read or `ext_wr_n` for a write. A read takes precedence if both requests are raised. `data_oe` is 1 only for an external write.
- R9: In single chip mode no external strobe is ever driven and `gpio_free` is 1.
- R10: A valid access outside every internal region and external window (including the unused space 00F800H–00FEFFH) raises `unmapped` for one cycle, with no select and no strobe.
- R11: `data_pullup` follows the software pull-up bit on every cycle that carries no external access, and is 0 during an external access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Start mode pin, 1 = MCU, 0 = MPU |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_single | input | 1 | Requested bus mode, 1 = single chip |
| cfg_pullup | input | 1 | Pull-up control bit value |
| cpu_addr | input | 22 | CPU address |
| cpu_rd | input | 1 | Read cycle request |
| cpu_wr | input | 1 | Write cycle request |
| int_sel | output | 5 | Internal region selects |
| ext_ce_n | output | 1 | External chip enable, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| data_oe | output | 1 | Data bus output enable toward external memory |
| data_pullup | output | 1 | Data bus pull-up control |
| gpio_free | output | 1 | Bus pins free for port use |
| unmapped | output | 1 | Unmapped access flag |

## Verification
Selects, strobes, `data_oe`, `data_pullup` and `unmapped` are due one clock edge after the access is driven. `gpio_free` reflects a configuration write at the very edge that takes it. The driver applies each access on a falling edge and queues the result expected for the next rising edge. The monitor pops and compares 2 ns after that rising edge. A configuration cycle queues old-mode values for the registered decode outputs and the new mode for `gpio_free`.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int SEL_W = 5;
  localparam int SEL_ROM  = 0;
  localparam int SEL_RAM  = 1;
  localparam int SEL_DISP = 2;
  localparam int SEL_IO   = 3;
  localparam int SEL_FONT = 4;

  // Internal region bounds, indexed by select bit
  localparam logic [31:0] REG_LO [SEL_W] = '{32'h000000, 32'h00C000, 32'h00D800, 32'h00FF00, 32'h010000};
  localparam logic [31:0] REG_HI [SEL_W] = '{32'h00BFFF, 32'h00D7FF, 32'h00F7FF, 32'h00FFFF, 32'h0EFFFF};

  // External windows
  localparam logic [31:0] MCU_EXT_LO = 32'h100000;
  localparam logic [31:0] MCU_EXT_HI = 32'h3FFFFF;
  localparam logic [31:0] MPU_EXT_LO = 32'h0F0000;
  localparam logic [31:0] MPU_EXT_HI = 32'h2FFFFF;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ext;
    logic             miss;
  } dec_t;
endpackage

// File: rtl/bmd_mode_ctrl.sv
module bmd_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mode_pin,
  input  logic cfg_we,
  input  logic cfg_single,
  input  logic cfg_pullup,
  output logic mpu_q,
  output logic single_q,
  output logic pullup_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mpu_q    <= ~mode_pin;
      single_q <= mode_pin;
      pullup_q <= 1'b0;
    end else if (cfg_we) begin
      pullup_q <= cfg_pullup;
      single_q <= cfg_single & ~mpu_q;
    end
  end
endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mpu,
  input  logic              single,
  output dec_t              dec
);
  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0]      a32;
  logic [SEL_W-1:0] in_win;
  logic             ext_mcu;
  logic             ext_mpu;

  assign a32 = {{PAD_W{1'b0}}, addr};

  for (genvar i = 0; i < SEL_W; i++) begin : g_win
    assign in_win[i] = (a32 >= REG_LO[i]) && (a32 <= REG_HI[i]);
  end

  assign ext_mcu = (a32 >= MCU_EXT_LO) && (a32 <= MCU_EXT_HI);
  assign ext_mpu = in_win[SEL_ROM] || ((a32 >= MPU_EXT_LO) && (a32 <= MPU_EXT_HI));

  always_comb begin
    dec.sel          = in_win;
    dec.sel[SEL_ROM] = in_win[SEL_ROM] & ~mpu;
    if (single)   dec.ext = 1'b0;
    else if (mpu) dec.ext = ext_mpu;
    else          dec.ext = ext_mcu;
    dec.miss = ~(|dec.sel) & ~dec.ext;
  end
endmodule

// File: rtl/bmd_strobe_gen.sv
module bmd_strobe_gen
  import bmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  dec_t             dec,
  input  logic             rd,
  input  logic             wr,
  input  logic             pullup_q,
  output logic [SEL_W-1:0] int_sel,
  output logic             ext_ce_n,
  output logic             ext_rd_n,
  output logic             ext_wr_n,
  output logic             data_oe,
  output logic             data_pullup,
  output logic             unmapped
);
  logic access;
  logic ext_hit;
  logic ext_write;

  assign access    = rd | wr;
  assign ext_hit   = access & dec.ext;
  assign ext_write = ext_hit & wr & ~rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_sel     <= '0;
      ext_ce_n    <= 1'b1;
      ext_rd_n    <= 1'b1;
      ext_wr_n    <= 1'b1;
      data_oe     <= 1'b0;
      data_pullup <= 1'b0;
      unmapped    <= 1'b0;
    end else begin
      int_sel     <= access ? dec.sel : '0;
      ext_ce_n    <= ~ext_hit;
      ext_rd_n    <= ~(ext_hit & rd);
      ext_wr_n    <= ~ext_write;
      data_oe     <= ext_write;
      data_pullup <= pullup_q & ~ext_hit;
      unmapped    <= access & dec.miss;
    end
  end
endmodule

// File: rtl/bus_mode_decoder.sv
module bus_mode_decoder
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin,
  input  logic              cfg_we,
  input  logic              cfg_single,
  input  logic              cfg_pullup,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [SEL_W-1:0]  int_sel,
  output logic              ext_ce_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              data_oe,
  output logic              data_pullup,
  output logic              gpio_free,
  output logic              unmapped
);
  logic mpu_q;
  logic single_q;
  logic pullup_q;
  dec_t dec;

  bmd_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_pin   (mode_pin),
    .cfg_we     (cfg_we),
    .cfg_single (cfg_single),
    .cfg_pullup (cfg_pullup),
    .mpu_q      (mpu_q),
    .single_q   (single_q),
    .pullup_q   (pullup_q)
  );

  bmd_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (cpu_addr),
    .mpu    (mpu_q),
    .single (single_q),
    .dec    (dec)
  );

  bmd_strobe_gen u_strb (
    .clk         (clk),
    .rst         (rst),
    .dec         (dec),
    .rd          (cpu_rd),
    .wr          (cpu_wr),
    .pullup_q    (pullup_q),
    .int_sel     (int_sel),
    .ext_ce_n    (ext_ce_n),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .data_oe     (data_oe),
    .data_pullup (data_pullup),
    .unmapped    (unmapped)
  );

  assign gpio_free = single_q;
endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mpu_q,
  input logic             single_q,
  input logic [SEL_W-1:0] int_sel,
  input logic             ext_ce_n,
  input logic             ext_rd_n,
  input logic             ext_wr_n,
  input logic             data_oe,
  input logic             gpio_free,
  input logic             unmapped
);
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mpu_q)); // R1
  AST_MPU_REFUSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mpu_q |-> !single_q); // R3
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_sel)); // R4
  AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (|int_sel) |-> (ext_ce_n && ext_rd_n && ext_wr_n && !data_oe)); // R7
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !ext_ce_n); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> ext_wr_n); // R8
  AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (gpio_free && $past(gpio_free)) |-> ext_ce_n); // R9
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (ext_ce_n && (int_sel == '0))); // R10
endmodule

bind bus_mode_decoder bmd_checker #(.SEL_W(bmd_pkg::SEL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mpu_q     (mpu_q),
  .single_q  (single_q),
  .int_sel   (int_sel),
  .ext_ce_n  (ext_ce_n),
  .ext_rd_n  (ext_rd_n),
  .ext_wr_n  (ext_wr_n),
  .data_oe   (data_oe),
  .gpio_free (gpio_free),
  .unmapped  (unmapped)
);

// File: tb/bus_mode_decoder_tb_top.sv
`timescale 1ns/1ps
module bus_mode_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_pin = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_single = 1'b0;
  logic        cfg_pullup = 1'b0;
  logic [21:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [4:0]  int_sel;
  logic        ext_ce_n, ext_rd_n, ext_wr_n, data_oe, data_pullup, gpio_free, unmapped;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0] sel;
    logic ce_n, rd_n, wr_n, oe, pu, gpio, unm;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // model state derived from requirements
  logic m_mpu = 1'b0;
  logic m_single = 1'b1;
  logic m_pu = 1'b0;

  always #5 clk = ~clk;

  bus_mode_decoder dut_i (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .cfg_we(cfg_we),
    .cfg_single(cfg_single), .cfg_pullup(cfg_pullup), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .int_sel(int_sel), .ext_ce_n(ext_ce_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .data_oe(data_oe),
    .data_pullup(data_pullup), .gpio_free(gpio_free), .unmapped(unmapped)
  );

  task automatic chk(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [21:0] addr, input logic rd, input logic wr, input string tag);
    exp_t e;
    int unsigned a = int'(addr);
    logic ext = 1'b0;
    logic acc = rd | wr;
    logic hit;
    e.sel = '0;
    if (a <= 32'h00BFFF) begin
      if (!m_mpu) e.sel[0] = 1'b1;
      else if (!m_single) ext = 1'b1;
    end else if (a <= 32'h00D7FF) e.sel[1] = 1'b1;
    else if (a <= 32'h00F7FF) e.sel[2] = 1'b1;
    else if (a <= 32'h00FEFF) ext = 1'b0;
    else if (a <= 32'h00FFFF) e.sel[3] = 1'b1;
    else if (a <= 32'h0EFFFF) e.sel[4] = 1'b1;
    else if (!m_single) begin
      if (m_mpu) ext = (a <= 32'h2FFFFF);
      else       ext = (a >= 32'h100000);
    end
    if (!acc) e.sel = '0;
    hit    = acc & ext;
    e.ce_n = ~hit;
    e.rd_n = ~(hit & rd);
    e.wr_n = ~(hit & wr & ~rd);
    e.oe   = hit & wr & ~rd;
    e.pu   = m_pu & ~hit;
    e.gpio = m_single;
    e.unm  = acc & ~ext & (e.sel == '0);
    e.tag  = tag;
    return e;
  endfunction

  task automatic access(input logic [21:0] addr, input logic rd, input logic wr, input string tag);
    @(negedge clk);
    cpu_addr = addr; cpu_rd = rd; cpu_wr = wr;
    sb_q.push_back(model(addr, rd, wr, tag));
  endtask

  task automatic cfg_write(input logic single, input logic pu, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    cfg_we = 1'b1; cfg_single = single; cfg_pullup = pu;
    e = model(22'h0, 1'b0, 1'b0, tag);
    m_pu = pu;
    m_single = single & ~m_mpu;
    e.gpio = m_single;
    sb_q.push_back(e);
    @(negedge clk);
    cfg_we = 1'b0;
    sb_q.push_back(model(22'h0, 1'b0, 1'b0, tag));
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    wait (sb_q.size() == 0);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cfg_we = 1'b0;
    rst = 1'b1; mode_pin = pin;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", "int_sel", int_sel, 5'd0);
    chk("R2", "ext_ce_n", {4'd0, ext_ce_n}, 5'd1);
    chk("R2", "ext_rd_n/wr_n", {3'd0, ext_rd_n, ext_wr_n}, 5'd3);
    chk("R2", "unmapped", {4'd0, unmapped}, 5'd0);
    chk("R2", "data_pullup", {4'd0, data_pullup}, 5'd0);
    chk("R2", "gpio_free", {4'd0, gpio_free}, {4'd0, pin});
    rst = 1'b0;
    m_mpu = ~pin; m_single = pin; m_pu = 1'b0;
  endtask

  // monitor: pops one expected item per edge, 2 ns after it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.tag, "int_sel", int_sel, e.sel);
        chk(e.tag, "ce/rd/wr_n", {2'd0, ext_ce_n, ext_rd_n, ext_wr_n}, {2'd0, e.ce_n, e.rd_n, e.wr_n});
        chk(e.tag, "oe/pullup", {3'd0, data_oe, data_pullup}, {3'd0, e.oe, e.pu});
        chk(e.tag, "gpio/unmapped", {3'd0, gpio_free, unmapped}, {3'd0, e.gpio, e.unm});
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);                               // MCU, single chip
    mode_pin = 1'b0;                              // R1: ignored after reset
    access(22'h000100, 1, 0, "R1_R4_rom");
    access(22'h00C010, 0, 1, "R4_ram");
    access(22'h00D900, 1, 0, "R4_disp");
    access(22'h00FF05, 1, 0, "R4_io");
    access(22'h020000, 1, 0, "R4_font");
    access(22'h00F900, 1, 0, "R10_unused");
    access(22'h200000, 1, 0, "R9_single_no_ext");
    access(22'h300000, 0, 1, "R9_single_wr");
    access(22'h000000, 0, 0, "R11_idle");
    cfg_write(1'b0, 1'b1, "R3_mcu_to_exp");
    access(22'h100000, 1, 0, "R5_lo");
    access(22'h3FFFFF, 0, 1, "R5_hi_wr");
    access(22'h0F0000, 1, 0, "R10_mcu_gap");
    access(22'h000100, 1, 0, "R7_R11_int_pullup");
    access(22'h2FFFFF, 1, 1, "R8_rd_priority");
    access(22'h0FFFFF, 0, 1, "R10_gap_hi");
    cfg_write(1'b1, 1'b0, "R3_mcu_single_ok");
    access(22'h100000, 1, 0, "R9_back_single");
    do_reset(1'b0);                               // MPU, expansion
    mode_pin = 1'b1;                              // R1: ignored after reset
    access(22'h000100, 1, 0, "R1_R6_rom_ext");
    access(22'h00BFFF, 0, 1, "R6_rom_top_wr");
    access(22'h00C000, 1, 0, "R6_ram_int");
    access(22'h00FF00, 0, 1, "R6_R7_io_int");
    access(22'h050000, 1, 0, "R6_font_int");
    access(22'h0F0000, 1, 0, "R6_ext_lo");
    access(22'h2FFFFF, 0, 1, "R6_ext_hi");
    access(22'h300000, 1, 0, "R10_mpu_above");
    access(22'h00F800, 1, 0, "R10_mpu_unused");
    cfg_write(1'b1, 1'b1, "R3_mpu_refuse");
    access(22'h000200, 1, 0, "R3_still_exp");
    access(22'h00D000, 1, 0, "R11_int_pu");
    access(22'h000000, 0, 0, "R11_idle_pu");
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule